// File: doc/BRIEF.md
# Dual-Mode FIFO Read Stage

This block is the read-side end of a small single-clock FIFO. Words enter through a write port, wait in a register array, and leave through one output register. Whether that register fills on request or by itself is fixed by a mode input. The block samples that input only while the synchronous active-low reset is held.

In standard mode a word moves to the output only when the consumer asks for it. The read-side flag means "empty" and the write-side flag means "full". In fall-through mode the oldest word moves to the output without a request. The read-side flag then means "a valid word is on the output", and the write-side flag means "a write will be accepted".

Because of this remapping, fall-through stages chain with a single AND gate. The upstream data drives the downstream write data. The upstream output-valid flag, ANDed with the downstream write-ready flag, is both the upstream read strobe and the downstream write strobe. Each added stage adds its capacity to the total depth.

A newly written word becomes visible to the read side through a pointer delay of `SYNC_STAGES` registers (default 2). This gives a first-word latency of `SYNC_STAGES+1` clock edges. That latency is three edges at the defaults.

Top module: `ftq_stage`

## Requirements
- R1: The mode is taken from `fall_mode_i` on every clock edge while `rst_n` is low (0 = standard, 1 = fall-through). Changing `fall_mode_i` while `rst_n` is high has no effect on flag meaning or data.
- R2: After reset, `rd_data_o` is 0. In standard mode `rd_flag_o`=1 and `wr_flag_o`=0. In fall-through mode `rd_flag_o`=0 and `wr_flag_o`=1.
- R3: In standard mode, `rd_data_o` changes only on an edge where `rd_en_i`=1 and the FIFO is not empty. It then shows the oldest unread word, in write order.
- R4: In standard mode, `rd_flag_o` (1 = empty) falls after the second edge following the write edge of a word into an empty FIFO. It rises right after the edge that reads the last visible word.
- R5: In standard mode, a read while `rd_flag_o`=1 leaves `rd_data_o` unchanged.
- R6: In standard mode, `wr_flag_o` (1 = full) rises right after the edge that stores the DEPTH-th unread word. A write while full is dropped and never appears at the output.
- R7: In fall-through mode, a word written into an empty FIFO appears on `rd_data_o` with `rd_flag_o`=1 right after the third edge after its write edge, with `rd_en_i` held low throughout.
- R8: In fall-through mode, while `rd_flag_o`=1 and `rd_en_i`=0, both `rd_data_o` and `rd_flag_o` hold. A read either brings the next word or, when none is visible, drops `rd_flag_o` to 0.
- R9: In fall-through mode, `wr_flag_o` (1 = ready) stays 1 through DEPTH writes and falls right after the edge that stores the (DEPTH+1)-th unread word. The output register holds one word beyond the array.
- R10: Two fall-through stages joined by the one-gate link deliver every word in write order, under random write and read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| fall_mode_i | input | 1 | Mode select: 0 standard, 1 fall-through |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write word |
| wr_flag_o | output | 1 | Standard: full; fall-through: write-ready |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Output register |
| rd_flag_o | output | 1 | Standard: empty; fall-through: output-valid |

## Verification
The case hardest to reach is a fall-through stage whose output register is valid and whose array is full at the same moment. This happens while the next stage is stalled. The chained test creates it by stalling the downstream reader at random for long stretches while the source keeps writing. This makes the link strobe stop and restart against the delayed pointer many times. A separate directed fill checks the DEPTH+1 capacity with idle gaps, so every pointer update is visible before the next write.

// File: rtl/ftq_pkg.sv
// Shared types for the dual-mode FIFO read stage.
package ftq_pkg;
    // Read-side behaviour, latched during reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/ftq_store.sv
// ftq_store: register array with its write pointer and full detection.
// Assumes DEPTH is a power of two. Reads are combinational from rd_ptr_i.
module ftq_store #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_ptr_i,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic              full_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic              wr_ok;

    // Accept a write only when space remains.
    always_comb begin
        full_o = ((wr_ptr_q - rd_ptr_i) == FULL_CNT);
        wr_ok  = wr_en_i && !full_o;
    end

    // Advance the write pointer on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (wr_ok) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
        end
    end

    // Store accepted words; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[wr_ptr_q[ADDR_W-1:0]] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_ptr_i[ADDR_W-1:0]];
    assign wr_ptr_o  = wr_ptr_q;
endmodule

// File: rtl/ftq_ptr_sync.sv
// ftq_ptr_sync: fixed delay line that shows the write pointer to the
// read side STAGES edges late. This sets the first-word latency.
module ftq_ptr_sync #(
    parameter int PTR_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift the pointer one register further each edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (g == 0) begin
                stage_q[g] <= ptr_i;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign ptr_o = stage_q[STAGES-1];
endmodule

// File: rtl/ftq_out_stage.sv
// ftq_out_stage: output register and read pointer. In standard mode it
// loads only on request. In fall-through mode it loads whenever it is free
// and a word is visible. Assumes wr_ptr_vis_i never runs behind rd_ptr_o.
module ftq_out_stage
    import ftq_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_mode_e          mode_i,
    input  logic              rd_en_i,
    input  logic [PTR_W-1:0]  wr_ptr_vis_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [PTR_W-1:0]  rd_ptr_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_flag_o
);
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              avail;
    logic              load;
    logic              drop;

    // Decide whether the register loads or empties this edge.
    always_comb begin
        avail = (wr_ptr_vis_i != rd_ptr_q);
        if (mode_i == MODE_FALL) begin
            load = avail && (!valid_q || rd_en_i);
            drop = !avail && valid_q && rd_en_i;
        end else begin
            load = avail && rd_en_i;
            drop = 1'b0;
        end
    end

    // Output word, its valid bit and the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            data_q   <= '0;
            valid_q  <= 1'b0;
        end else if (load) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
            data_q   <= mem_data_i;
            valid_q  <= 1'b1;
        end else if (drop) begin
            valid_q  <= 1'b0;
        end
    end

    assign rd_ptr_o  = rd_ptr_q;
    assign rd_data_o = data_q;
    assign rd_flag_o = (mode_i == MODE_FALL) ? valid_q : !avail;
endmodule

// File: rtl/ftq_stage.sv
// ftq_stage: single-clock FIFO whose read side follows a reset-latched
// mode. The flags change meaning with the mode so that fall-through
// stages chain with one AND gate. Assumes DEPTH is a power of two.
module ftq_stage
    import ftq_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_mode_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_flag_o,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_flag_o
);
    rd_mode_e          mode_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  wr_ptr_vis;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] mem_data;
    logic              full;

    // Capture the mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rd_mode_e'(fall_mode_i);
        end
    end

    ftq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_ptr_i  (rd_ptr),
        .wr_ptr_o  (wr_ptr),
        .full_o    (full),
        .rd_data_o (mem_data)
    );

    ftq_ptr_sync #(
        .PTR_W  (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr_i (wr_ptr),
        .ptr_o (wr_ptr_vis)
    );

    ftq_out_stage #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_q),
        .rd_en_i      (rd_en_i),
        .wr_ptr_vis_i (wr_ptr_vis),
        .mem_data_i   (mem_data),
        .rd_ptr_o     (rd_ptr),
        .rd_data_o    (rd_data_o),
        .rd_flag_o    (rd_flag_o)
    );

    assign wr_flag_o = (mode_q == MODE_FALL) ? !full : full;
endmodule

// File: rtl/ftq_stage_chk.sv
// ftq_stage_chk: temporal properties of ftq_stage, bound to every instance.
module ftq_stage_chk
    import ftq_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input rd_mode_e          mode_q,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              rd_flag_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  rd_ptr
);
    logic [PTR_W-1:0] occ;
    assign occ = wr_ptr - rd_ptr;

    // R1: the mode never moves outside reset.
    a_r1_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    // R5: a standard-mode read while empty leaves the output alone.
    a_r5_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && rd_flag_o && rd_en_i) |=> $stable(rd_data_o));

    // R8: an unread fall-through word stays put.
    a_r8_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FALL && rd_flag_o && !rd_en_i) |=>
            (rd_flag_o && $stable(rd_data_o)));

    // R6: array occupancy never exceeds DEPTH.
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));

    // R6: a write at full occupancy does not move the write pointer.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && occ == PTR_W'(DEPTH)) |=> $stable(wr_ptr));
endmodule

bind ftq_stage ftq_stage_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .PTR_W  (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .rd_flag_o (rd_flag_o),
    .rd_data_o (rd_data_o),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/ftq_stage_tb.sv
module ftq_stage_tb;
    localparam int DW    = 18;
    localparam int DEPTH = 8;
    localparam int NCHAIN = 200;

    // Vector fields: [39] wr, [38] rd, [37:20] wdata, [19] exp rd_flag,
    // [18] exp wr_flag, [17:0] exp rd_data. Standard mode.
    localparam int NVEC = 10;
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 18'h00011, 1'b1, 1'b0, 18'h00000},
        {1'b0, 1'b0, 18'h00000, 1'b1, 1'b0, 18'h00000},
        {1'b0, 1'b0, 18'h00000, 1'b0, 1'b0, 18'h00000},
        {1'b0, 1'b1, 18'h00000, 1'b1, 1'b0, 18'h00011},
        {1'b0, 1'b1, 18'h00000, 1'b1, 1'b0, 18'h00011},
        {1'b1, 1'b0, 18'h00022, 1'b1, 1'b0, 18'h00011},
        {1'b1, 1'b0, 18'h00033, 1'b1, 1'b0, 18'h00011},
        {1'b0, 1'b1, 18'h00000, 1'b0, 1'b0, 18'h00011},
        {1'b0, 1'b1, 18'h00000, 1'b0, 1'b0, 18'h00022},
        {1'b0, 1'b1, 18'h00000, 1'b1, 1'b0, 18'h00033}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fall_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tb_rd_en = 1'b0;
    logic          rd_en2 = 1'b0;
    logic          chain_on = 1'b0;
    logic          wr_flag1, rd_flag1, wr_flag2, rd_flag2;
    logic [DW-1:0] rd_data1, rd_data2;
    logic          link;
    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    logic          done = 1'b0;

    always #5 clk = ~clk;

    assign link = chain_on && rd_flag1 && wr_flag2;

    ftq_stage #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fall_mode_i(fall_mode),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_flag_o(wr_flag1),
        .rd_en_i(chain_on ? link : tb_rd_en),
        .rd_data_o(rd_data1), .rd_flag_o(rd_flag1)
    );

    ftq_stage #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .fall_mode_i(fall_mode),
        .wr_en_i(link), .wr_data_i(rd_data1), .wr_flag_o(wr_flag2),
        .rd_en_i(rd_en2), .rd_data_o(rd_data2), .rd_flag_o(rd_flag2)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        fall_mode = mode;
        wr_en = 1'b0;
        tb_rd_en = 1'b0;
        rd_en2 = 1'b0;
        chain_on = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    function automatic logic [DW-1:0] seq(input int n);
        return DW'(n * 7 + 3);
    endfunction

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R2: standard reset state
        do_reset(1'b0);
        chk("R2 std rd_flag", 32'(rd_flag1), 32'd1);
        chk("R2 std wr_flag", 32'(wr_flag1), 32'd0);
        chk("R2 rd_data", 32'(rd_data1), 32'd0);

        // R1: mode input toggled after reset must not change semantics
        fall_mode = 1'b1;

        // R3 R4 R5: table walk in standard mode
        for (int i = 0; i < NVEC; i++) begin
            wr_en    = VEC[i][39];
            tb_rd_en = VEC[i][38];
            wr_data  = VEC[i][37:20];
            tick();
            chk("R1 R4 rd_flag vector", 32'(rd_flag1), 32'(VEC[i][19]));
            chk("R6 wr_flag vector", 32'(wr_flag1), 32'(VEC[i][18]));
            chk("R3 R5 rd_data vector", 32'(rd_data1), 32'(VEC[i][17:0]));
        end
        wr_en = 1'b0;
        tb_rd_en = 1'b0;

        // R6: fill to DEPTH, then a dropped write
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1;
            wr_data = seq(100 + i);
            tick();
            chk("R6 full flag during fill", 32'(wr_flag1), (i == DEPTH-1) ? 32'd1 : 32'd0);
        end
        wr_data = 18'h3ffff;
        tick();
        wr_en = 1'b0;
        chk("R6 full after dropped write", 32'(wr_flag1), 32'd1);
        repeat (3) tick();
        for (int i = 0; i < DEPTH; i++) begin
            tb_rd_en = 1'b1;
            tick();
            chk("R3 R6 std drain order", 32'(rd_data1), 32'(seq(100 + i)));
        end
        chk("R4 empty after drain", 32'(rd_flag1), 32'd1);
        tick();
        chk("R5 R6 no dropped word", 32'(rd_data1), 32'(seq(100 + DEPTH - 1)));
        tb_rd_en = 1'b0;

        // R2: fall-through reset state
        do_reset(1'b1);
        chk("R2 fall rd_flag", 32'(rd_flag1), 32'd0);
        chk("R2 fall wr_flag", 32'(wr_flag1), 32'd1);

        // R7: first word appears after the third edge with no read
        wr_en = 1'b1;
        wr_data = 18'h00155;
        tick();
        wr_en = 1'b0;
        chk("R7 not yet e0", 32'(rd_flag1), 32'd0);
        tick();
        chk("R7 not yet e1", 32'(rd_flag1), 32'd0);
        tick();
        chk("R7 not yet e2", 32'(rd_flag1), 32'd0);
        tick();
        chk("R7 ready e3", 32'(rd_flag1), 32'd1);
        chk("R7 first word", 32'(rd_data1), 32'h155);

        // R8: hold without read, next word on read, then drop
        wr_en = 1'b1;
        wr_data = 18'h000aa;
        tick();
        wr_en = 1'b0;
        repeat (4) tick();
        chk("R8 hold flag", 32'(rd_flag1), 32'd1);
        chk("R8 hold data", 32'(rd_data1), 32'h155);
        tb_rd_en = 1'b1;
        tick();
        chk("R8 next word", 32'(rd_data1), 32'h0aa);
        chk("R8 next flag", 32'(rd_flag1), 32'd1);
        tick();
        tb_rd_en = 1'b0;
        chk("R8 drop flag", 32'(rd_flag1), 32'd0);

        // R9: capacity DEPTH+1 with input-ready polarity
        for (int i = 0; i <= DEPTH; i++) begin
            wr_en = 1'b1;
            wr_data = seq(300 + i);
            tick();
            wr_en = 1'b0;
            chk("R9 ready during fill", 32'(wr_flag1), (i == DEPTH) ? 32'd0 : 32'd1);
            repeat (4) tick();
        end
        chk("R9 head word", 32'(rd_data1), 32'(seq(300)));
        for (int i = 1; i <= DEPTH; i++) begin
            tb_rd_en = 1'b1;
            tick();
            chk("R9 fall drain order", 32'(rd_data1), 32'(seq(300 + i)));
        end
        tick();
        tb_rd_en = 1'b0;
        chk("R9 empty after drain", 32'(rd_flag1), 32'd0);

        // R10: two chained fall-through stages with random stalls
        do_reset(1'b1);
        chain_on = 1'b1;
        begin
            int tx = 0;
            int rx = 0;
            int errs = 0;
            while (rx < NCHAIN) begin
                if (rd_flag2 && ($urandom % 3 != 0)) begin
                    if (rd_data2 !== seq(rx)) errs++;
                    chk("R10 chain order", 32'(rd_data2), 32'(seq(rx)));
                    rx++;
                    rd_en2 = 1'b1;
                end else begin
                    rd_en2 = 1'b0;
                end
                if (tx < NCHAIN && wr_flag1 && ($urandom % 2 == 0)) begin
                    wr_en = 1'b1;
                    wr_data = seq(tx);
                    tx++;
                end else begin
                    wr_en = 1'b0;
                end
                tick();
            end
            rd_en2 = 1'b0;
            wr_en = 1'b0;
            repeat (6) tick();
            chk("R10 nothing left over", 32'(rd_flag2), 32'd0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule